// File: doc/BRIEF.md
# Counter-Based Runtime Power Estimator

This block turns per-cycle activity pulses into a running estimate of chip power. A small bank of event counters is shared between several groups of events. The bank serves one group for a programmable number of cycles, called a slot, and then moves on to the next group. A full pass over all groups is a round. When a slot closes, its counts are copied into hold registers. The counters then restart on the next group at once, so software never has to read anything out between groups.

When a round closes, every component converts its event count into an access rate. The rate is the count multiplied by a fixed-point reciprocal of the slot length. Two models can then be applied to each component.

- **Gated model:** a peak-power coefficient × a scaling coefficient × the rate, plus a constant ungated term.
- **Linear model:** a coefficient × the rate. The total then also gains an idle-power constant.

The per-component terms and their sum are registered together with a one-cycle strobe. Coefficients, slot length, reciprocal and model choice are staged: they take effect only at the start of the next round.

Top module: `pwr_estimator`

## Requirements
- R1: A synchronous active-low reset clears counters, hold registers, staged and active configuration, outputs and the strobe. After reset the slot length reads 0.
- R2: In slot r of a round, counter k counts only `ev_pulse[r*N_CNT+k]`, and pulses of other groups are ignored. A slot lasts the active length in cycles, where a length of 0 acts as 1. A round is N_ROT slots.
- R3: A counter saturates at 2^CNT_W-1 instead of wrapping.
- R4: A pulse in the final cycle of a slot is included in that slot's count. The next group starts counting in the following cycle, with no lost cycle.
- R5: The rate of component i uses event i. It is (count × reciprocal) >> 8, saturated to 16 bits and read as unsigned Q8.8.
- R6: In the gated model (`lin_mode`=0), term = sat(sat(sat(peak×scale>>8) × rate>>8) + ungated). Every saturation clamps to 0xFFFF.
- R7: In the linear model (`lin_mode`=1), term = sat(peak×rate>>8). The scale and ungated fields have no effect.
- R8: `est_total` is the exact sum of all terms, plus the idle constant in the linear model only. It is wide enough never to wrap.
- R9: At the close of each round, `est_comp`/`est_total` load and `est_valid` pulses high for exactly the next cycle. Outside that load the outputs hold.
- R10: Writes are staged and become active at the next round boundary, including a write presented in the last cycle of a round. The round in progress uses the values active at its start. `coef_fld` encodes 0 peak, 1 scale, 2 ungated and 3 idle (for idle, `coef_idx` is ignored). Slot length/reciprocal (`ivl_we`) and `lin_mode` are staged the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_pulse | input | N_CNT*N_ROT | One activity pulse per event per cycle |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | clog2(N_COMP) | Component addressed by the write |
| coef_fld | input | 2 | Coefficient field selector |
| coef_wdata | input | Q_W | Coefficient value, unsigned Q8.8 |
| ivl_we | input | 1 | Slot-length write strobe |
| ivl_len | input | LEN_W | Slot length in cycles |
| ivl_recip | input | RCP_W | Reciprocal of the slot length, Q0.16 scaling |
| lin_mode | input | 1 | Selects the linear model |
| est_valid | output | 1 | One-cycle strobe on a new estimate |
| est_comp | output | N_COMP*Q_W | Per-component terms, component i at bits [i*Q_W +: Q_W] |
| est_total | output | Q_W+clog2(N_COMP+1) | Sum of terms |

## Verification
Two actions can land on the same round-closing clock edge. One is the publication of the estimate. The other is a staged coefficient write, or an event pulse in the slot's last cycle. The bench provokes this by writing one coefficient in the middle of a round and another in that round's very last cycle, while events keep pulsing through the last cycle. The estimate for that round must match a model built on the old coefficients with every last-cycle pulse counted. The following round must reflect both new coefficients.

// File: rtl/pwr_est_pkg.sv
// Shared definitions for the power estimator.
// Assumes coefficient and rate values use unsigned fixed point with FRAC_BITS fraction bits.
package pwr_est_pkg;
    typedef enum logic [1:0] {
        FLD_PEAK    = 2'd0,
        FLD_SCALE   = 2'd1,
        FLD_UNGATED = 2'd2,
        FLD_IDLE    = 2'd3
    } coef_fld_e;

    localparam int FRAC_BITS = 8;
endpackage

// File: rtl/pwr_coef_bank.sv
// Staged coefficient and interval storage.
// Writes land in a pending copy. The active copy loads from the pending copy,
// with any same-cycle write merged in, only when 'commit' marks a round boundary.
// Assumes commit is a single-cycle strobe from the rotor.
module pwr_coef_bank
    import pwr_est_pkg::*;
#(
    parameter int N_COMP = 22,
    parameter int IDX_W  = 5,
    parameter int Q_W    = 16,
    parameter int LEN_W  = 16,
    parameter int RCP_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  coef_fld_e        wr_fld,
    input  logic [Q_W-1:0]   wr_data,
    input  logic             ivl_we,
    input  logic [LEN_W-1:0] ivl_len,
    input  logic [RCP_W-1:0] ivl_recip,
    input  logic             lin_in,
    input  logic             commit,
    output logic [Q_W-1:0]   act_peak  [N_COMP],
    output logic [Q_W-1:0]   act_scale [N_COMP],
    output logic [Q_W-1:0]   act_ungat [N_COMP],
    output logic [Q_W-1:0]   act_idle,
    output logic [LEN_W-1:0] act_len,
    output logic [RCP_W-1:0] act_recip,
    output logic             act_lin
);
    logic [Q_W-1:0]   pend_peak  [N_COMP];
    logic [Q_W-1:0]   pend_scale [N_COMP];
    logic [Q_W-1:0]   pend_ungat [N_COMP];
    logic [Q_W-1:0]   pend_idle;
    logic [LEN_W-1:0] pend_len;
    logic [RCP_W-1:0] pend_recip;

    logic [Q_W-1:0]   nxt_peak  [N_COMP];
    logic [Q_W-1:0]   nxt_scale [N_COMP];
    logic [Q_W-1:0]   nxt_ungat [N_COMP];
    logic [Q_W-1:0]   nxt_idle;
    logic [LEN_W-1:0] nxt_len;
    logic [RCP_W-1:0] nxt_recip;
    logic             idx_ok;

    // Guard against component indices beyond the table.
    assign idx_ok = ({1'b0, wr_idx} < (IDX_W+1)'(N_COMP));

    // Merge this cycle's write into the pending image.
    always_comb begin
        nxt_peak  = pend_peak;
        nxt_scale = pend_scale;
        nxt_ungat = pend_ungat;
        nxt_idle  = pend_idle;
        nxt_len   = pend_len;
        nxt_recip = pend_recip;
        if (wr_en) begin
            unique case (wr_fld)
                FLD_PEAK:    if (idx_ok) nxt_peak[wr_idx]  = wr_data;
                FLD_SCALE:   if (idx_ok) nxt_scale[wr_idx] = wr_data;
                FLD_UNGATED: if (idx_ok) nxt_ungat[wr_idx] = wr_data;
                FLD_IDLE:    nxt_idle = wr_data;
            endcase
        end
        if (ivl_we) begin
            nxt_len   = ivl_len;
            nxt_recip = ivl_recip;
        end
    end

    // Pending copy follows every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_COMP; i++) begin
                pend_peak[i]  <= '0;
                pend_scale[i] <= '0;
                pend_ungat[i] <= '0;
            end
            pend_idle  <= '0;
            pend_len   <= '0;
            pend_recip <= '0;
        end else begin
            pend_peak  <= nxt_peak;
            pend_scale <= nxt_scale;
            pend_ungat <= nxt_ungat;
            pend_idle  <= nxt_idle;
            pend_len   <= nxt_len;
            pend_recip <= nxt_recip;
        end
    end

    // Active copy changes only on a round boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_COMP; i++) begin
                act_peak[i]  <= '0;
                act_scale[i] <= '0;
                act_ungat[i] <= '0;
            end
            act_idle  <= '0;
            act_len   <= '0;
            act_recip <= '0;
            act_lin   <= 1'b0;
        end else if (commit) begin
            act_peak  <= nxt_peak;
            act_scale <= nxt_scale;
            act_ungat <= nxt_ungat;
            act_idle  <= nxt_idle;
            act_len   <= nxt_len;
            act_recip <= nxt_recip;
            act_lin   <= lin_in;
        end
    end

    // R10: active configuration is frozen between round boundaries.
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_len) && $stable(act_recip) && $stable(act_lin) && $stable(act_idle)));
endmodule

// File: rtl/pwr_evt_rotor.sv
// Slot timer, rotation control and the shared counter bank.
// Counter k serves event rot*N_CNT+k during slot rot. At a slot close the
// counts (including the closing cycle's pulses) move to hold registers.
// Assumes len is stable within a round (the coefficient bank guarantees this).
module pwr_evt_rotor #(
    parameter int N_CNT = 6,
    parameter int N_ROT = 4,
    parameter int CNT_W = 16,
    parameter int LEN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CNT*N_ROT-1:0] ev,
    input  logic [LEN_W-1:0]       len,
    output logic [CNT_W-1:0]       counts [N_CNT*N_ROT],
    output logic                   round_end
);
    localparam int N_EV  = N_CNT * N_ROT;
    localparam int ROT_W = (N_ROT > 1) ? $clog2(N_ROT) : 1;

    logic [ROT_W-1:0] rot;
    logic [LEN_W-1:0] slot_cnt;
    logic [LEN_W-1:0] len_m1;
    logic             slot_last;
    logic             rot_last;
    logic [N_CNT-1:0] ev_grp;
    logic [CNT_W-1:0] cnt     [N_CNT];
    logic [CNT_W-1:0] cnt_nxt [N_CNT];
    logic [CNT_W-1:0] held    [N_EV];

    // Slot boundary decode; a zero length behaves as one cycle.
    always_comb begin
        len_m1    = (len == '0) ? '0 : len - LEN_W'(1);
        slot_last = (slot_cnt >= len_m1);
        rot_last  = (rot == ROT_W'(N_ROT - 1));
        round_end = slot_last && rot_last;
        ev_grp    = ev[int'(rot) * N_CNT +: N_CNT];
    end

    // Saturating increment of each counter by its routed pulse.
    always_comb begin
        for (int k = 0; k < N_CNT; k++) begin
            cnt_nxt[k] = (&cnt[k]) ? cnt[k] : cnt[k] + CNT_W'(ev_grp[k]);
        end
    end

    // Slot cycle counter and rotation index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            rot      <= '0;
        end else if (slot_last) begin
            slot_cnt <= '0;
            rot      <= rot_last ? '0 : rot + ROT_W'(1);
        end else begin
            slot_cnt <= slot_cnt + LEN_W'(1);
        end
    end

    // Counter bank: restart at every slot close.
    always_ff @(posedge clk) begin
        for (int k = 0; k < N_CNT; k++) begin
            if (!rst_n || slot_last) cnt[k] <= '0;
            else                     cnt[k] <= cnt_nxt[k];
        end
    end

    generate
        for (genvar j = 0; j < N_EV; j++) begin : g_hold
            localparam int GRP  = j / N_CNT;
            localparam int LANE = j % N_CNT;

            // Hold register for event j, captured when its group's slot closes.
            always_ff @(posedge clk) begin
                if (!rst_n)                                    held[j] <= '0;
                else if (slot_last && rot == ROT_W'(GRP))      held[j] <= cnt_nxt[LANE];
            end

            if (GRP == N_ROT - 1) begin : g_live
                // Last group is read straight from the counters at round close.
                assign counts[j] = round_end ? cnt_nxt[LANE] : held[j];
            end else begin : g_held
                assign counts[j] = held[j];
            end
        end

        for (genvar k = 0; k < N_CNT; k++) begin : g_chk
            // R3: a count never exceeds the cycles elapsed in its slot.
            assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
                32'(cnt[k]) <= 32'(slot_cnt));
        end
    endgenerate

    // R2: rotation index stays within the configured groups.
    assert_rot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rot <= ROT_W'(N_ROT - 1));

    // R4: a closing slot hands over to a fresh slot the next cycle.
    assert_slot_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        slot_last |=> (slot_cnt == '0));
endmodule

// File: rtl/pwr_term_unit.sv
// One component's power term: rate normalisation followed by the gated or
// linear model, all with saturating fixed-point arithmetic.
// Assumes Q_W-bit unsigned values with FRAC fraction bits; purely combinational
// (clk and rst_n only clock the local checks).
module pwr_term_unit #(
    parameter int Q_W   = 16,
    parameter int CNT_W = 16,
    parameter int RCP_W = 16,
    parameter int FRAC  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [RCP_W-1:0] recip,
    input  logic [Q_W-1:0]   peak,
    input  logic [Q_W-1:0]   scale,
    input  logic [Q_W-1:0]   ungat,
    input  logic             lin,
    output logic [Q_W-1:0]   term
);
    localparam int RF_W = CNT_W + RCP_W;
    localparam int PQ_W = 2 * Q_W;

    logic [RF_W-1:0] rate_full;
    logic [Q_W-1:0]  rate;
    logic [PQ_W-1:0] ms_full;
    logic [Q_W-1:0]  ms;
    logic [PQ_W-1:0] pr_full;
    logic [Q_W-1:0]  pr;
    logic [PQ_W-1:0] lin_full;
    logic [Q_W-1:0]  lin_term;
    logic [Q_W:0]    sum_ext;

    // Access rate: count times reciprocal, rescaled and clamped.
    always_comb begin
        rate_full = (RF_W'(count) * RF_W'(recip)) >> FRAC;
        rate      = (|rate_full[RF_W-1:Q_W]) ? '1 : rate_full[Q_W-1:0];
    end

    // Gated model: peak x scale x rate, then add the ungated floor.
    always_comb begin
        ms_full = (PQ_W'(peak) * PQ_W'(scale)) >> FRAC;
        ms      = (|ms_full[PQ_W-1:Q_W]) ? '1 : ms_full[Q_W-1:0];
        pr_full = (PQ_W'(ms) * PQ_W'(rate)) >> FRAC;
        pr      = (|pr_full[PQ_W-1:Q_W]) ? '1 : pr_full[Q_W-1:0];
        sum_ext = {1'b0, pr} + {1'b0, ungat};
    end

    // Linear model: coefficient x rate.
    always_comb begin
        lin_full = (PQ_W'(peak) * PQ_W'(rate)) >> FRAC;
        lin_term = (|lin_full[PQ_W-1:Q_W]) ? '1 : lin_full[Q_W-1:0];
    end

    // Model select with saturation of the final add.
    always_comb begin
        if (lin)               term = lin_term;
        else if (sum_ext[Q_W]) term = '1;
        else                   term = sum_ext[Q_W-1:0];
    end

    // R6: the saturating add never drops below the ungated floor.
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lin |-> (term >= ungat));

    // R5: a zero count yields a zero rate contribution in either model.
    assert_zero_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (lin ? (term == '0) : (term == ungat)));
endmodule

// File: rtl/pwr_estimator.sv
// Top of the counter-based power estimator.
// Ties the rotor, staged coefficient bank and per-component term units
// together, sums the terms and registers the estimate at each round close.
// Assumes N_COMP <= N_CNT*N_ROT; component i is driven by event i.
module pwr_estimator
    import pwr_est_pkg::*;
#(
    parameter int N_CNT  = 6,
    parameter int N_ROT  = 4,
    parameter int N_COMP = 22,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 16,
    parameter int Q_W    = 16,
    parameter int RCP_W  = 16,
    parameter int IDX_W  = (N_COMP > 1) ? $clog2(N_COMP) : 1,
    parameter int TOT_W  = Q_W + $clog2(N_COMP + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CNT*N_ROT-1:0]  ev_pulse,
    input  logic                    coef_we,
    input  logic [IDX_W-1:0]        coef_idx,
    input  logic [1:0]              coef_fld,
    input  logic [Q_W-1:0]          coef_wdata,
    input  logic                    ivl_we,
    input  logic [LEN_W-1:0]        ivl_len,
    input  logic [RCP_W-1:0]        ivl_recip,
    input  logic                    lin_mode,
    output logic                    est_valid,
    output logic [N_COMP*Q_W-1:0]   est_comp,
    output logic [TOT_W-1:0]        est_total
);
    localparam int N_EV = N_CNT * N_ROT;

    logic [CNT_W-1:0] counts    [N_EV];
    logic             round_end;
    logic [Q_W-1:0]   act_peak  [N_COMP];
    logic [Q_W-1:0]   act_scale [N_COMP];
    logic [Q_W-1:0]   act_ungat [N_COMP];
    logic [Q_W-1:0]   act_idle;
    logic [LEN_W-1:0] act_len;
    logic [RCP_W-1:0] act_recip;
    logic             act_lin;
    logic [Q_W-1:0]   term      [N_COMP];
    logic [TOT_W-1:0] total_sum;

    pwr_evt_rotor #(
        .N_CNT (N_CNT),
        .N_ROT (N_ROT),
        .CNT_W (CNT_W),
        .LEN_W (LEN_W)
    ) u_rotor (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev_pulse),
        .len       (act_len),
        .counts    (counts),
        .round_end (round_end)
    );

    pwr_coef_bank #(
        .N_COMP (N_COMP),
        .IDX_W  (IDX_W),
        .Q_W    (Q_W),
        .LEN_W  (LEN_W),
        .RCP_W  (RCP_W)
    ) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (coef_we),
        .wr_idx    (coef_idx),
        .wr_fld    (coef_fld_e'(coef_fld)),
        .wr_data   (coef_wdata),
        .ivl_we    (ivl_we),
        .ivl_len   (ivl_len),
        .ivl_recip (ivl_recip),
        .lin_in    (lin_mode),
        .commit    (round_end),
        .act_peak  (act_peak),
        .act_scale (act_scale),
        .act_ungat (act_ungat),
        .act_idle  (act_idle),
        .act_len   (act_len),
        .act_recip (act_recip),
        .act_lin   (act_lin)
    );

    generate
        for (genvar i = 0; i < N_COMP; i++) begin : g_term
            pwr_term_unit #(
                .Q_W   (Q_W),
                .CNT_W (CNT_W),
                .RCP_W (RCP_W),
                .FRAC  (FRAC_BITS)
            ) u_term (
                .clk   (clk),
                .rst_n (rst_n),
                .count (counts[i]),
                .recip (act_recip),
                .peak  (act_peak[i]),
                .scale (act_scale[i]),
                .ungat (act_ungat[i]),
                .lin   (act_lin),
                .term  (term[i])
            );
        end
    endgenerate

    // Sum of all terms, plus the idle constant in the linear model.
    always_comb begin
        total_sum = act_lin ? TOT_W'(act_idle) : '0;
        for (int i = 0; i < N_COMP; i++) begin
            total_sum = total_sum + TOT_W'(term[i]);
        end
    end

    // Publish register: loads at round close, strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est_valid <= 1'b0;
            est_comp  <= '0;
            est_total <= '0;
        end else begin
            est_valid <= round_end;
            if (round_end) begin
                est_total <= total_sum;
                for (int i = 0; i < N_COMP; i++) begin
                    est_comp[i*Q_W +: Q_W] <= term[i];
                end
            end
        end
    end

    // R9: a closing round is followed by the strobe.
    assert_publish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        round_end |=> est_valid);

    // R9: outputs hold while no round closes.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !round_end |=> ($stable(est_total) && $stable(est_comp)));

    generate
        if (N_ROT > 1) begin : g_pulse_chk
            // R9: the strobe lasts a single cycle when a round spans several slots.
            assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
                est_valid |=> !est_valid);
        end
    endgenerate

    // R8: the linear model total never falls below its idle constant.
    assert_total_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act_lin |-> (total_sum >= TOT_W'(act_idle)));
endmodule

// File: tb/pwr_estimator_bench.sv
module pwr_estimator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC    = 6;
    localparam int NR    = 4;
    localparam int NCOMP = 22;
    localparam int CW    = 8;
    localparam int NEV   = NC * NR;
    localparam int TOTW  = 16 + $clog2(NCOMP + 1);
    localparam int CMAX  = (1 << CW) - 1;

    // Stimulus vectors: slot length, reciprocal, model, coefficient bases.
    localparam int VN = 5;
    localparam int V_LEN [VN] = '{4, 10, 300, 4, 0};
    localparam int V_RCP [VN] = '{16384, 6553, 218, 65535, 65535};
    localparam int V_LIN [VN] = '{0, 1, 0, 0, 1};
    localparam int V_PK  [VN] = '{'h0200, 'h0300, 'h0180, 'hF000, 'h0120};
    localparam int V_SC  [VN] = '{'h0100, 'h7777, 'h0280, 'hF000, 'h0100};
    localparam int V_UG  [VN] = '{'h0010, 'h0500, 'h0040, 'hF000, 'h0033};
    localparam string V_TAG [VN] = '{"R6/R5", "R7", "R3", "R6-sat", "R2-len0/R7"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NEV-1:0]   ev_pulse = '0;
    logic             coef_we = 1'b0;
    logic [4:0]       coef_idx = '0;
    logic [1:0]       coef_fld = '0;
    logic [15:0]      coef_wdata = '0;
    logic             ivl_we = 1'b0;
    logic [15:0]      ivl_len = '0;
    logic [15:0]      ivl_recip = '0;
    logic             lin_mode = 1'b0;
    logic             est_valid;
    logic [NCOMP*16-1:0] est_comp;
    logic [TOTW-1:0]  est_total;

    int n_checks = 0;
    int n_fail   = 0;
    bit timed_out = 0;

    int b_peak [NCOMP];
    int b_scale[NCOMP];
    int b_ungat[NCOMP];
    int b_idle, b_len, b_rcp, b_lin;
    int want [NEV];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_estimator #(.N_CNT(NC), .N_ROT(NR), .N_COMP(NCOMP), .CNT_W(CW)) u_pwr_estimator (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_fld(coef_fld), .coef_wdata(coef_wdata),
        .ivl_we(ivl_we), .ivl_len(ivl_len), .ivl_recip(ivl_recip), .lin_mode(lin_mode),
        .est_valid(est_valid), .est_comp(est_comp), .est_total(est_total)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint clamp16(input longint v);
        return (v > 65535) ? 65535 : v;
    endfunction

    // Expected term from the requirement formulas.
    function automatic longint exp_term(input int i);
        longint leff, c, rate, ms, pr;
        leff = (b_len == 0) ? 1 : b_len;
        c = want[i];
        if (c > leff) c = leff;
        if (c > CMAX) c = CMAX;
        rate = clamp16((c * b_rcp) >>> 8);
        if (b_lin != 0) return clamp16((longint'(b_peak[i]) * rate) >>> 8);
        ms = clamp16((longint'(b_peak[i]) * b_scale[i]) >>> 8);
        pr = clamp16((ms * rate) >>> 8);
        return clamp16(pr + b_ungat[i]);
    endfunction

    task automatic wr_coef(input int idx, input int fld, input int val);
        coef_we = 1'b1; coef_idx = 5'(idx); coef_fld = 2'(fld); coef_wdata = 16'(val);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic configure(input int v);
        b_len = V_LEN[v]; b_rcp = V_RCP[v]; b_lin = V_LIN[v];
        ivl_we = 1'b1; ivl_len = 16'(b_len); ivl_recip = 16'(b_rcp);
        lin_mode = (b_lin != 0);
        @(negedge clk);
        ivl_we = 1'b0;
        for (int i = 0; i < NCOMP; i++) begin
            b_peak[i]  = (V_PK[v] + i * 'h31) & 'hFFFF;
            b_scale[i] = (V_SC[v] + i * 'h07) & 'hFFFF;
            b_ungat[i] = (V_UG[v] + i * 'h13) & 'hFFFF;
            wr_coef(i, 0, b_peak[i]);
            wr_coef(i, 1, b_scale[i]);
            wr_coef(i, 2, b_ungat[i]);
        end
        b_idle = (V_UG[v] * 2 + 5) & 'hFFFF;
        wr_coef(0, 3, b_idle);
    endtask

    task automatic set_pattern(input int v);
        int leff;
        leff = (b_len == 0) ? 1 : b_len;
        for (int e = 0; e < NEV; e++) want[e] = (e * 37 + v * 53) % (leff + 2);
    endtask

    task automatic wait_valid();
        int n;
        n = 0;
        while (!est_valid && n < 6000) begin
            @(negedge clk);
            n++;
        end
        check(est_valid == 1'b1, "R9 strobe arrival", est_valid, 1);
    endtask

    // Drive one full round of events; optional staged writes at chosen cycles.
    task automatic run_round(input int mid_c, input bit last_wr, input int val_a, input int val_b);
        int leff, tot;
        leff = (b_len == 0) ? 1 : b_len;
        tot = NR * leff;
        for (int c = 0; c < tot; c++) begin
            for (int e = 0; e < NEV; e++) ev_pulse[e] = ((c % leff) < want[e]);
            coef_we = 1'b0;
            if (c == mid_c) begin
                coef_we = 1'b1; coef_idx = 5'd0; coef_fld = 2'd0; coef_wdata = 16'(val_a);
            end
            if (last_wr && c == tot - 1) begin
                coef_we = 1'b1; coef_idx = 5'd1; coef_fld = 2'd0; coef_wdata = 16'(val_b);
            end
            @(negedge clk);
        end
        ev_pulse = '0;
        coef_we = 1'b0;
    endtask

    task automatic check_estimate(input string tag);
        longint sum, t;
        sum = (b_lin != 0) ? b_idle : 0;
        check(est_valid == 1'b1, {tag, " R9 strobe"}, est_valid, 1);
        for (int i = 0; i < NCOMP; i++) begin
            t = exp_term(i);
            sum += t;
            check(longint'(est_comp[i*16 +: 16]) == t, {tag, " R4 term"}, est_comp[i*16 +: 16], t);
        end
        check(longint'(est_total) == sum, {tag, " R8 total"}, est_total, sum);
    endtask

    task automatic main_seq();
        int n;
        longint held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(est_valid == 1'b0, "R1 valid at reset", est_valid, 0);
        check(est_total == '0, "R1 total at reset", est_total, 0);
        check(est_comp == '0, "R1 comp at reset", 0, 0);
        rst_n = 1'b1;
        // R2: zero length after reset acts as one cycle, so a round is NR cycles
        n = 0;
        while (!est_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == NR, "R2 round length with len 0", n, NR);
        check(est_total == '0, "R1 cleared coefficients", est_total, 0);

        for (int v = 0; v < VN; v++) begin
            configure(v);
            wait_valid();
            set_pattern(v);
            run_round(-1, 1'b0, 0, 0);
            check_estimate(V_TAG[v]);
            held = est_total;
            @(negedge clk);
            check(est_valid == 1'b0, "R9 single-cycle strobe", est_valid, 0);
            check(longint'(est_total) == held, "R9 hold", est_total, held);
        end

        // R10: mid-round and last-cycle writes apply only to the next round
        configure(0);
        wait_valid();
        set_pattern(7);
        run_round(2, 1'b1, 'h0A00, 'h0B00);
        check_estimate("R10 old coefs");
        b_peak[0] = 'h0A00;
        b_peak[1] = 'h0B00;
        run_round(-1, 1'b0, 0, 0);
        check_estimate("R10 new coefs");

        // R1: reset in mid-run clears the published estimate
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(est_valid == 1'b0, "R1 valid after reset", est_valid, 0);
        check(est_total == '0, "R1 total after reset", est_total, 0);
        check(est_comp == '0, "R1 comp after reset", 0, 0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule